// File: doc/BRIEF.md
# Serial Burst Write Engine

This block takes a burst of words shifted in one bit per enabled clock, as carried by a JTAG data register. It writes each word to a memory bus through a single request/acknowledge master port. A setup strobe first loads the starting address, the number of words and the word width. After that, the engine waits for a start marker in the serial stream. It then counts data bits, assembles each word LSB first, and issues a bus write as soon as the word is complete.

For every word the host gets one status bit back, which tells it whether the bus was free to take that word. After the last word the host shifts in a 32-bit checksum. The engine compares it with a checksum it computed itself over the received data bits and answers with a single match bit.

If the bus terminates a write with an error, a sticky flag is raised and the failing address is kept. Software reads both as one register and clears the flag by writing a 1 to it. Command decoding and TAP state handling sit outside this block.

Top module: `jtag_burst_writer`

## Requirements
- R1: After the setup strobe, serial bits of value 0 are ignored. The first 1 is the start marker: it is neither data nor checksum, and the data bits follow it.
- R2: The width code selects the word width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. Words arrive LSB first, and each complete word is presented on the bus data port zero-extended to 32 bits.
- R3: In the serial slot right after a word's last data bit, `tdo` carries that word's status bit: 1 when a bus write was issued for the word, 0 otherwise. Outside the status and match slots `tdo` is 0.
- R4: A word that completes while the previous bus write is still outstanding is dropped: no request is issued and its status bit is 0. A write that ends (ack or error) on the same clock edge where the word completes counts as free.
- R5: The first issued write uses the loaded address. The address advances by the word size in bytes (1, 2 or 4) only for words that were issued.
- R6: Once the loaded number of words has passed, the host shifts a 32-bit checksum LSB first. The next slot returns 1 on `tdo` exactly when it equals the local checksum. The local checksum starts at 0xFFFFFFFF; for each data bit b it shifts right by one and XORs in 0xEDB88320 when b differs from the bit shifted out.
- R7: `busReq` stays high with `busAddr`, `busData` and `busSize` unchanged until `busAck` or `busErr` is seen.
- R8: `busErr` on an outstanding write sets the sticky error flag, `errReg[0]`, and stores that write's address in `errReg[32:1]`. While the flag is set, later errors do not change the stored address.
- R9: A clock with `errWrEn` high and `errWrBit` = 1 clears the flag; with `errWrBit` = 0 it has no effect. A bus error in the same cycle as a clear wins, so the flag ends up set.
- R10: After reset `tdo`, `busReq` and `errReg` are 0. Shifting bits with no burst loaded starts no bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadBurst | input | 1 | Setup strobe: latch address, count and width, then wait for the start marker |
| loadAddr | input | 32 | Starting bus address |
| loadCount | input | 16 | Number of words in the burst |
| loadSize | input | 2 | Word width code (0: 8, 1: 16, 2/3: 32 bits) |
| shiftEn | input | 1 | One serial bit is taken on this clock |
| tdi | input | 1 | Serial input bit |
| tdo | output | 1 | Serial reply: status bit or match bit |
| busReq | output | 1 | Bus write request |
| busAddr | output | 32 | Bus write address |
| busData | output | 32 | Bus write data, zero-extended |
| busSize | output | 2 | Width code of the current write |
| busAck | input | 1 | Write accepted and finished |
| busErr | input | 1 | Write finished with an error |
| errWrEn | input | 1 | Write strobe for the error flag |
| errWrBit | input | 1 | Value written to the error flag (1 clears) |
| errReg | output | 33 | Failing address in bits 32:1, sticky flag in bit 0 |

## Verification
Two events can land on the same clock edge: the completion of a serial word and the end of the previous bus write. One stimulus row sets the responder latency equal to the word width, so the acknowledge comes on the exact edge where the next word's last bit arrives. That word must still get status 1 and be written at the advanced address. A latency one cycle longer must drop every second word and leave the address in place. A second collision, a bus error arriving together with a flag clear, is forced by having the responder pulse the clear in its error cycle. The flag must then read set, holding the new failing address.

// File: rtl/jbw_pkg.sv
package jbw_pkg;

  localparam int WORD_MAX = 32;

  typedef struct packed {
    logic loadCfg;
    logic dataBit;
    logic wordEnd;
    logic crcBit;
    logic crcEnd;
    logic showStatus;
    logic showMatch;
  } jbw_stb_t;

  function automatic logic [5:0] sizeBits(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd8;
      2'd1:    return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [2:0] sizeBytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/jbw_ctrl.sv
module jbw_ctrl
  import jbw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadBurst,
  input  logic [CNT_W-1:0] loadCount,
  input  logic [1:0]       loadSize,
  input  logic             shiftEn,
  input  logic             tdi,
  output jbw_stb_t         stb,
  output logic [1:0]       sizeQ
);

  localparam int BIT_W = $clog2(WORD_MAX) + 1;
  localparam logic [BIT_W-1:0] CRC_LAST = BIT_W'(31);

  typedef enum logic [2:0] {
    S_IDLE, S_HUNT, S_DATA, S_STAT, S_CRC, S_MATCH
  } st_t;

  st_t              st, stNext;
  logic [BIT_W-1:0] bitCnt, bitNext;
  logic [CNT_W-1:0] wordsLeft, leftNext;
  logic [BIT_W-1:0] wordLast;

  assign wordLast = BIT_W'(sizeBits(sizeQ)) - BIT_W'(1);

  always_comb begin
    stb      = '0;
    stNext   = st;
    bitNext  = bitCnt;
    leftNext = wordsLeft;
    if (loadBurst) begin
      stb.loadCfg = 1'b1;
      stNext      = S_HUNT;
      bitNext     = '0;
      leftNext    = loadCount;
    end else begin
      case (st)
        S_HUNT: if (shiftEn && tdi) begin
          bitNext = '0;
          stNext  = (wordsLeft == '0) ? S_CRC : S_DATA;
        end
        S_DATA: if (shiftEn) begin
          stb.dataBit = 1'b1;
          if (bitCnt == wordLast) begin
            stb.wordEnd = 1'b1;
            bitNext     = '0;
            stNext      = S_STAT;
          end else begin
            bitNext = bitCnt + BIT_W'(1);
          end
        end
        S_STAT: begin
          stb.showStatus = 1'b1;
          if (shiftEn) begin
            leftNext = wordsLeft - CNT_W'(1);
            stNext   = (wordsLeft == CNT_W'(1)) ? S_CRC : S_DATA;
          end
        end
        S_CRC: if (shiftEn) begin
          stb.crcBit = 1'b1;
          if (bitCnt == CRC_LAST) begin
            stb.crcEnd = 1'b1;
            bitNext    = '0;
            stNext     = S_MATCH;
          end else begin
            bitNext = bitCnt + BIT_W'(1);
          end
        end
        S_MATCH: begin
          stb.showMatch = 1'b1;
          if (shiftEn) stNext = S_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= S_IDLE;
      bitCnt    <= '0;
      wordsLeft <= '0;
      sizeQ     <= 2'd0;
    end else begin
      st        <= stNext;
      bitCnt    <= bitNext;
      wordsLeft <= leftNext;
      if (loadBurst) sizeQ <= loadSize;
    end
  end

  // R3
  status_follows_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wordEnd |=> stb.showStatus);

  // R6
  match_follows_crc_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.crcEnd |=> stb.showMatch);

endmodule

// File: rtl/jbw_datapath.sv
module jbw_datapath
  import jbw_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] CRC_POLY = 32'hEDB88320
) (
  input  logic              clk,
  input  logic              rstN,
  input  jbw_stb_t          stb,
  input  logic [1:0]        sizeQ,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              tdi,
  input  logic              busAck,
  input  logic              busErr,
  input  logic              errWrEn,
  input  logic              errWrBit,
  output logic              tdo,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic [WORD_MAX-1:0] busData,
  output logic [1:0]        busSize,
  output logic [ADDR_W:0]   errReg
);

  logic [WORD_MAX-1:0] shiftQ, shiftNext, wordVal;
  logic [31:0]         crcQ, crcStep, crcInQ, crcInNext;
  logic [ADDR_W-1:0]   nextAddrQ, errAddrQ;
  logic                statusQ, matchQ, errFlagQ;
  logic                busFree, accept, errEvent, clrEvent;

  assign shiftNext = {tdi, shiftQ[WORD_MAX-1:1]};
  assign wordVal   = shiftNext >> (6'd32 - sizeBits(sizeQ));
  assign crcStep   = {1'b0, crcQ[31:1]} ^ (((tdi ^ crcQ[0]) != 1'b0) ? CRC_POLY : 32'd0);
  assign crcInNext = {tdi, crcInQ[31:1]};
  assign busFree   = !busReq || busAck || busErr;
  assign accept    = stb.wordEnd && busFree;
  assign errEvent  = busReq && busErr;
  assign clrEvent  = errWrEn && errWrBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ    <= '0;
      crcQ      <= '1;
      crcInQ    <= '0;
      nextAddrQ <= '0;
      statusQ   <= 1'b0;
      matchQ    <= 1'b0;
      busReq    <= 1'b0;
      busAddr   <= '0;
      busData   <= '0;
      busSize   <= 2'd0;
    end else begin
      if (stb.dataBit) begin
        shiftQ <= shiftNext;
        crcQ   <= crcStep;
      end
      if (stb.crcBit) crcInQ <= crcInNext;
      if (stb.crcEnd) matchQ <= (crcInNext == crcQ);
      if (stb.loadCfg) begin
        nextAddrQ <= loadAddr;
        crcQ      <= '1;
      end
      if (stb.wordEnd) statusQ <= accept;
      if (accept) begin
        busReq    <= 1'b1;
        busAddr   <= nextAddrQ;
        busData   <= wordVal;
        busSize   <= sizeQ;
        nextAddrQ <= nextAddrQ + ADDR_W'(sizeBytes(sizeQ));
      end else if (busAck || busErr) begin
        busReq <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlagQ <= 1'b0;
      errAddrQ <= '0;
    end else if (errEvent) begin
      errFlagQ <= 1'b1;
      if (!errFlagQ) errAddrQ <= busAddr;
    end else if (clrEvent) begin
      errFlagQ <= 1'b0;
    end
  end

  assign tdo    = stb.showStatus ? statusQ : (stb.showMatch ? matchQ : 1'b0);
  assign errReg = {errAddrQ, errFlagQ};

  // R7
  hold_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck && !busErr) |=> (busReq && $stable(busAddr) && $stable(busData) && $stable(busSize)));

  // R4
  req_after_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> $past(stb.wordEnd));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlagQ && !clrEvent) |=> (errFlagQ && $stable(errAddrQ)));

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlagQ && clrEvent && !errEvent) |=> !errFlagQ);

endmodule

// File: rtl/jtag_burst_writer.sv
module jtag_burst_writer
  import jbw_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          CNT_W    = 16,
  parameter logic [31:0] CRC_POLY = 32'hEDB88320
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                loadBurst,
  input  logic [ADDR_W-1:0]   loadAddr,
  input  logic [CNT_W-1:0]    loadCount,
  input  logic [1:0]          loadSize,
  input  logic                shiftEn,
  input  logic                tdi,
  output logic                tdo,
  output logic                busReq,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [WORD_MAX-1:0] busData,
  output logic [1:0]          busSize,
  input  logic                busAck,
  input  logic                busErr,
  input  logic                errWrEn,
  input  logic                errWrBit,
  output logic [ADDR_W:0]     errReg
);

  jbw_stb_t   stb;
  logic [1:0] sizeQ;

  jbw_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadBurst (loadBurst),
    .loadCount (loadCount),
    .loadSize  (loadSize),
    .shiftEn   (shiftEn),
    .tdi       (tdi),
    .stb       (stb),
    .sizeQ     (sizeQ)
  );

  jbw_datapath #(.ADDR_W(ADDR_W), .CRC_POLY(CRC_POLY)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .sizeQ    (sizeQ),
    .loadAddr (loadAddr),
    .tdi      (tdi),
    .busAck   (busAck),
    .busErr   (busErr),
    .errWrEn  (errWrEn),
    .errWrBit (errWrBit),
    .tdo      (tdo),
    .busReq   (busReq),
    .busAddr  (busAddr),
    .busData  (busData),
    .busSize  (busSize),
    .errReg   (errReg)
  );

endmodule

// File: tb/jtag_burst_writer_test.sv
`timescale 1ns/1ps
module jtag_burst_writer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadBurst = 1'b0;
  logic [31:0] loadAddr = '0;
  logic [15:0] loadCount = '0;
  logic [1:0]  loadSize = '0;
  logic        shiftEn = 1'b0;
  logic        tdi = 1'b0;
  logic        tdo;
  logic        busReq;
  logic [31:0] busAddr;
  logic [31:0] busData;
  logic [1:0]  busSize;
  logic        busAck = 1'b0;
  logic        busErr = 1'b0;
  logic        errWrEn;
  logic        errWrBit;
  logic [32:0] errReg;

  logic tbClr = 1'b0, tbBit = 1'b0, respClr = 1'b0;
  assign errWrEn  = tbClr | respClr;
  assign errWrBit = respClr ? 1'b1 : tbBit;

  always #2 clk = ~clk;

  jtag_burst_writer uut (
    .clk(clk), .rstN(rstN), .loadBurst(loadBurst), .loadAddr(loadAddr),
    .loadCount(loadCount), .loadSize(loadSize), .shiftEn(shiftEn), .tdi(tdi),
    .tdo(tdo), .busReq(busReq), .busAddr(busAddr), .busData(busData),
    .busSize(busSize), .busAck(busAck), .busErr(busErr), .errWrEn(errWrEn),
    .errWrBit(errWrBit), .errReg(errReg)
  );

  int tests = 0, fails = 0;

  // bus responder: completes a request delay+1 edges after it appears
  int respDelay = 0, rCnt = 0, logCnt = 0;
  bit respErr = 1'b0, respClrOnErr = 1'b0;
  logic [31:0] logA [16];
  logic [31:0] logD [16];

  always @(negedge clk) begin
    busAck  = 1'b0;
    busErr  = 1'b0;
    respClr = 1'b0;
    if (busReq) begin
      if (rCnt == respDelay) begin
        if (respErr) begin
          busErr = 1'b1;
          if (respClrOnErr) respClr = 1'b1;
        end else begin
          busAck = 1'b1;
          if (logCnt < 16) begin
            logA[logCnt] = busAddr;
            logD[logCnt] = busData;
          end
          logCnt = logCnt + 1;
        end
        rCnt = 0;
      end else begin
        rCnt = rCnt + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic shiftBit(input logic b, output logic got);
    @(negedge clk);
    tdi = b;
    shiftEn = 1'b1;
    #0.1;
    got = tdo;
    @(posedge clk);
  endtask

  function automatic logic [31:0] crcUpd(input logic [31:0] c, input logic b);
    return {1'b0, c[31:1]} ^ ((b ^ c[0]) ? 32'hEDB88320 : 32'd0);
  endfunction

  task automatic runBurst(input logic [1:0] sz, input int cnt, input logic [31:0] a0,
                          input logic [31:0] seed, input int dly, input bit badCrc,
                          input bit errMode);
    int wb, bytes, t, lastReq, nExp;
    logic [31:0] crc, w, mask, ea;
    logic [31:0] expA [16];
    logic [31:0] expD [16];
    logic got;
    bit acc;
    wb = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    bytes = wb / 8;
    mask = (wb == 32) ? 32'hFFFFFFFF : ((32'd1 << wb) - 32'd1);
    respDelay = dly;
    respErr = errMode;
    logCnt = 0;
    @(negedge clk);
    shiftEn = 1'b0;
    loadBurst = 1'b1; loadAddr = a0; loadCount = 16'(cnt); loadSize = sz;
    @(posedge clk);
    #0.5 loadBurst = 1'b0;
    // R1: zeros before the start marker must be ignored
    repeat (3) shiftBit(1'b0, got);
    shiftBit(1'b1, got);
    t = 0; lastReq = -100; crc = 32'hFFFFFFFF; ea = a0; nExp = 0;
    for (int k = 0; k < cnt; k++) begin
      w = (seed ^ (32'(k) * 32'h9E3779B9)) & mask;
      for (int b = 0; b < wb; b++) begin
        shiftBit(w[b], got);
        crc = crcUpd(crc, w[b]);
        t++;
      end
      acc = (t >= lastReq + dly + 1);
      if (acc) begin
        lastReq = t;
        if (!errMode && nExp < 16) begin
          expA[nExp] = ea; expD[nExp] = w; nExp++;
        end
        ea = ea + 32'(bytes);
      end
      shiftBit(1'b0, got);
      t++;
      check(acc ? "R3 status of issued word" : "R4 status of dropped word", 64'(got), 64'(acc));
    end
    for (int b = 0; b < 32; b++) shiftBit(badCrc ? ~crc[b] : crc[b], got);
    shiftBit(1'b0, got);
    check("R6 checksum match bit", 64'(got), 64'(!badCrc));
    @(negedge clk);
    shiftEn = 1'b0;
    repeat (20) @(posedge clk);
    #0.5;
    check("R4 R5 number of bus writes", 64'(logCnt), 64'(nExp));
    for (int i = 0; i < nExp && i < logCnt; i++) begin
      check("R5 write address", 64'(logA[i]), 64'(expA[i]));
      check("R1 R2 write data", 64'(logD[i]), 64'(expD[i]));
    end
  endtask

  task automatic pulseClear(input logic b);
    @(negedge clk);
    tbClr = 1'b1; tbBit = b;
    @(posedge clk);
    #0.5 tbClr = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]  size;
    logic [3:0]  count;
    logic [31:0] addr;
    logic [31:0] seed;
    logic [3:0]  delay;
    logic        badCrc;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd3, 32'h0000_1000, 32'h0000_00A5, 4'd2,  1'b0},
    '{2'd1, 4'd2, 32'h0000_2000, 32'h0000_C3E1, 4'd5,  1'b0},
    '{2'd2, 4'd2, 32'h0000_3000, 32'hDEAD_BEEF, 4'd1,  1'b0},
    '{2'd0, 4'd3, 32'h0000_1100, 32'h0000_0017, 4'd8,  1'b0},
    '{2'd0, 4'd4, 32'h0000_1200, 32'h0000_0055, 4'd9,  1'b0},
    '{2'd2, 4'd1, 32'h0000_3300, 32'h1234_5678, 4'd0,  1'b1},
    '{2'd3, 4'd2, 32'h0000_3400, 32'h8000_0001, 4'd0,  1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic got;
    int reqSeen;
    repeat (3) @(posedge clk);
    #0.5;
    check("R10 reset tdo", 64'(tdo), 64'd0);
    check("R10 reset busReq", 64'(busReq), 64'd0);
    check("R10 reset errReg", 64'(errReg), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    reqSeen = 0;
    for (int i = 0; i < 40; i++) begin
      shiftBit(1'b1, got);
      if (got !== 1'b0 || busReq !== 1'b0) reqSeen++;
    end
    @(negedge clk);
    shiftEn = 1'b0;
    check("R10 shifting without burst", 64'(reqSeen), 64'd0);

    for (int v = 0; v < NV; v++)
      runBurst(VECS[v].size, int'(VECS[v].count), VECS[v].addr, VECS[v].seed,
               int'(VECS[v].delay), VECS[v].badCrc, 1'b0);

    // bus error capture and clearing
    runBurst(2'd2, 1, 32'h0000_4000, 32'h0BAD_0001, 1, 1'b0, 1'b1);
    check("R8 error captured", 64'(errReg), {31'd0, 32'h0000_4000, 1'b1});
    runBurst(2'd2, 1, 32'h0000_5000, 32'h0BAD_0002, 1, 1'b0, 1'b1);
    check("R8 first address kept", 64'(errReg), {31'd0, 32'h0000_4000, 1'b1});
    pulseClear(1'b0);
    check("R9 write of 0 ignored", 64'(errReg), {31'd0, 32'h0000_4000, 1'b1});
    pulseClear(1'b1);
    check("R9 write of 1 clears", 64'(errReg[0]), 64'd0);
    respClrOnErr = 1'b1;
    runBurst(2'd1, 1, 32'h0000_6000, 32'h0000_7777, 2, 1'b0, 1'b1);
    respClrOnErr = 1'b0;
    check("R9 error wins over clear", 64'(errReg), {31'd0, 32'h0000_6000, 1'b1});
    pulseClear(1'b1);
    check("R9 final clear", 64'(errReg[0]), 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule